// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a two-wire (I2C) slave that reaches a small bank of byte registers through an internal pointer. The system clock samples SCL and SDA. The slave never drives SDA high: it pulls the line low through an open-drain enable. The slave address is seven bits long. Its upper four bits come from a parameter, the next bit comes from a strap pin, and the two lowest bits are zero.

In a write, the first byte after the address loads the register pointer. Every byte after that is stored at the pointer, and the pointer then steps forward. To read at a chosen register, the master first writes the pointer, then sends a repeated START with the read address. The slave then returns bytes from the pointer onwards, MSB first, for as long as the master acknowledges them. The whole bank is also presented as a flat parallel bus for neighbouring logic. A byte that is cut short by a STOP or a repeated START is dropped.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset every register reads 0x00, the pointer is 0 and `sda_oe` is low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The slave only ever asserts `sda_oe` while SCL is low.
- R3: The slave acknowledges the 7-bit address {ADDR_HI, `addr_pin`, 2'b00}, which is followed by an R/W bit (0 = write, 1 = read) in the LSB. It acknowledges by pulling SDA low during the ninth clock of the byte.
- R4: After any other address, including the general-call address 0x00, the slave does not acknowledge and does not drive SDA until the next START.
- R5: In a write, the first byte after the address sets the pointer from its low log2(NREG) bits. Each later byte is stored at the pointer and acknowledged.
- R6: The pointer steps by one after each data byte, whether written or read. From NREG-1 it wraps to 0.
- R7: A read sequence (write the pointer, repeated START, read address) returns the register at the pointer, MSB first. A read with no pointer byte continues from the current pointer.
- R8: The slave sends the next byte after each master ACK. After a master NACK it leaves SDA released, so that the master can issue a STOP.
- R9: A data byte interrupted by a STOP or a repeated START before its eighth bit changes no register.
- R10: Register k appears on `regs_o[8k+7:8k]`.
- R11: The address follows the level of `addr_pin`. With ADDR_HI=1011 the address is 0x5C when the pin is 1 and 0x58 when the pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pin | input | 1 | Strap bit that becomes address bit 2 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NREG*8 | Flat register contents, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its defaults: ADDR_HI=1011, NREG=16 and two synchroniser stages. With 16 registers, bursts of up to six bytes at random pointers often run past register 15, so the wrap is exercised in both writes and reads. The fixed upper bits leave 0x00 and the other-pin address 0x58 as non-matching addresses, and toggling `addr_pin` makes 0x58 the valid one. The bus quarter-period of six clocks is longer than the two-stage synchroniser delay, which lets the acknowledge and data bits settle before the master samples them.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] CNT_ACK = 4'd8;
    localparam logic [3:0] CNT_END = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WR,
        ST_RD
    } bus_st_e;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_reg_pkg::*;
#(
    parameter int NREG = 16,
    parameter int PW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PW-1:0]          waddr,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic [PW-1:0]          raddr,
    output logic [BYTE_W-1:0]      rdata,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    logic [BYTE_W-1:0] mem_d [NREG];
    logic [BYTE_W-1:0] mem_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_comb begin
            mem_d[k] = (we && (waddr == PW'(k))) ? wdata : mem_q[k];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[k] <= '0;
            else        mem_q[k] <= mem_d[k];
        end
        assign regs_o[k*BYTE_W +: BYTE_W] = mem_q[k];
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1011,
    parameter int         NREG    = 16,
    parameter int         PW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              addr_pin,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PW-1:0]     ptr_o,
    output logic [BYTE_W-1:0] wdata,
    output logic              busy
);
    typedef struct packed {
        bus_st_e           st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [PW-1:0]     ptr;
        logic              rw;
        logic              nack;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
    } fsm_t;

    fsm_t q_q, q_d;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic [6:0] my_addr;
    logic [PW-1:0] ptr_next;

    assign my_addr  = {ADDR_HI, addr_pin, 2'b00};
    assign ptr_next = (q_q.ptr == PW'(NREG - 1)) ? '0 : q_q.ptr + PW'(1);
    assign scl_rise = scl_s & ~q_q.scl_p;
    assign scl_fall = ~scl_s & q_q.scl_p;
    assign start_c  = scl_s & q_q.scl_p & q_q.sda_p & ~sda_s;
    assign stop_c   = scl_s & q_q.scl_p & ~q_q.sda_p & sda_s;

    always_comb begin
        q_d       = q_q;
        q_d.scl_p = scl_s;
        q_d.sda_p = sda_s;
        wr_en     = 1'b0;
        if (start_c) begin
            q_d.st  = ST_DEV;
            q_d.cnt = '0;
            q_d.oe  = 1'b0;
        end else if (stop_c) begin
            q_d.st = ST_IDLE;
            q_d.oe = 1'b0;
        end else begin
            case (q_q.st)
                ST_DEV, ST_PTR, ST_WR: begin
                    if (scl_rise && (q_q.cnt < CNT_ACK)) begin
                        q_d.sh  = {q_q.sh[BYTE_W-2:0], sda_s};
                        q_d.cnt = q_q.cnt + 4'd1;
                    end else if (scl_fall && (q_q.cnt == CNT_ACK)) begin
                        q_d.cnt = CNT_END;
                        q_d.oe  = 1'b1;
                        if (q_q.st == ST_DEV) begin
                            q_d.rw = q_q.sh[0];
                            if (q_q.sh[BYTE_W-1:1] != my_addr) begin
                                q_d.st = ST_IDLE;
                                q_d.oe = 1'b0;
                            end
                        end else if (q_q.st == ST_PTR) begin
                            q_d.ptr = q_q.sh[PW-1:0];
                        end else begin
                            wr_en   = 1'b1;
                            q_d.ptr = ptr_next;
                        end
                    end else if (scl_fall && (q_q.cnt == CNT_END)) begin
                        q_d.oe  = 1'b0;
                        q_d.cnt = '0;
                        if (q_q.st == ST_DEV && q_q.rw) begin
                            q_d.st = ST_RD;
                            q_d.sh = rdata;
                            q_d.oe = ~rdata[BYTE_W-1];
                        end else if (q_q.st == ST_DEV) begin
                            q_d.st = ST_PTR;
                        end else begin
                            q_d.st = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall && (q_q.cnt < CNT_ACK - 4'd1)) begin
                        q_d.cnt = q_q.cnt + 4'd1;
                        q_d.sh  = {q_q.sh[BYTE_W-2:0], 1'b0};
                        q_d.oe  = ~q_q.sh[BYTE_W-2];
                    end else if (scl_fall && (q_q.cnt == CNT_ACK - 4'd1)) begin
                        q_d.cnt = CNT_ACK;
                        q_d.oe  = 1'b0;
                    end else if (scl_rise && (q_q.cnt == CNT_ACK)) begin
                        q_d.nack = sda_s;
                        q_d.cnt  = CNT_END;
                        q_d.ptr  = ptr_next;
                    end else if (scl_fall && (q_q.cnt == CNT_END)) begin
                        if (q_q.nack) begin
                            q_d.st = ST_IDLE;
                        end else begin
                            q_d.cnt = '0;
                            q_d.sh  = rdata;
                            q_d.oe  = ~rdata[BYTE_W-1];
                        end
                    end
                end
                default: q_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.st    <= ST_IDLE;
            q_q.scl_p <= 1'b1;
            q_q.sda_p <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign sda_oe = q_q.oe;
    assign ptr_o  = q_q.ptr;
    assign wdata  = q_q.sh;
    assign busy   = (q_q.st != ST_IDLE);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b1011,
    parameter int         NREG        = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   addr_pin,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int PW = $clog2(NREG);

    logic [1:0]        line_s;
    logic              busy_w, wr_en_w;
    logic [PW-1:0]     ptr_w;
    logic [BYTE_W-1:0] wdata_w, rdata_w;

    i2c_in_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    i2c_slave_fsm #(.ADDR_HI(ADDR_HI), .NREG(NREG), .PW(PW)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .addr_pin (addr_pin),
        .rdata    (rdata_w),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en_w),
        .ptr_o    (ptr_w),
        .wdata    (wdata_w),
        .busy     (busy_w)
    );

    i2c_reg_bank #(.NREG(NREG), .PW(PW)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en_w),
        .waddr  (ptr_w),
        .wdata  (wdata_w),
        .raddr  (ptr_w),
        .rdata  (rdata_w),
        .regs_o (regs_o)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter int NREG = 16,
    parameter int PW   = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              busy,
    input logic              wr_en,
    input logic [PW-1:0]     ptr,
    input logic [NREG*8-1:0] regs_o
);
    // R2
    pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R4
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

    // R9
    reg_change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(wr_en));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == (($past(ptr) == PW'(NREG - 1)) ? '0 : $past(ptr) + PW'(1))));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NREG(NREG)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .busy   (busy_w),
    .wr_en  (wr_en_w),
    .ptr    (ptr_w),
    .regs_o (regs_o)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pin = 1'b1;
    logic sda_oe;
    logic [127:0] regs_o;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    logic [7:0] mreg [16];
    int mptr = 0;
    bit watch_oe = 0;
    bit oe_seen = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_reg_slave i_i2c_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_pin(pin), .sda_oe(sda_oe), .regs_o(regs_o)
    );

    always @(negedge clk) if (watch_oe && sda_oe) oe_seen = 1;

    function automatic logic [7:0] dev(input logic p, input logic rw);
        return {4'b1011, p, 2'b00, rw};
    endfunction

    function automatic int wrap(input int p);
        return (p + 1) % 16;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; w(Q); m_scl = 1; w(2 * Q); m_scl = 0; w(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1; w(Q); m_scl = 1; w(Q); b = sda_line; w(Q); m_scl = 0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 16; k++) chk(regs_o[8*k +: 8], mreg[k], req);
    endtask

    task automatic do_write(input logic [7:0] p, input int n);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev(pin, 1'b0), ack); chk({7'd0, ack}, 8'd1, "R3 write address ack");
        send_byte(p, ack); chk({7'd0, ack}, 8'd1, "R5 pointer ack");
        mptr = p & 8'h0F;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk({7'd0, ack}, 8'd1, "R5 data ack");
            mreg[mptr] = d;
            mptr = wrap(mptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input bit set_ptr, input logic [7:0] p, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        if (set_ptr) begin
            send_byte(dev(pin, 1'b0), ack); chk({7'd0, ack}, 8'd1, "R3 write address ack");
            send_byte(p, ack); chk({7'd0, ack}, 8'd1, "R5 pointer ack");
            mptr = p & 8'h0F;
            bus_start();
        end
        send_byte(dev(pin, 1'b1), ack); chk({7'd0, ack}, 8'd1, "R3 read address ack");
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(v, mreg[mptr], (i == 0) ? "R7 first read byte" : "R8 R6 burst read byte");
            mptr = wrap(mptr);
        end
        w(2);
        chk({7'd0, sda_oe}, 8'd0, "R8 released after NACK");
        chk({7'd0, sda_line}, 8'd1, "R8 SDA high after NACK");
        bus_stop();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL timeout (all) act=running exp=done");
        finish_run();
    end

    initial begin
        logic ack;
        void'($urandom(32'd4711));
        for (int k = 0; k < 16; k++) mreg[k] = 8'h00;
        w(10);
        rst_n = 1;
        w(5);
        // R1: reset state
        check_regs("R1 R10 reset value");
        chk({7'd0, sda_oe}, 8'd0, "R1 SDA released");
        do_read(0, 8'h00, 1);  // R1: pointer starts at 0

        // R5 R10: plain write burst
        do_write(8'h02, 3);
        check_regs("R5 R10 write burst");
        // R6: wrap across the last register
        do_write(8'h0E, 5);
        check_regs("R6 write wrap");
        do_read(1, 8'h0F, 3);

        // R4: general call is ignored
        watch_oe = 1; oe_seen = 0;
        bus_start();
        send_byte(8'h00, ack); chk({7'd0, ack}, 8'd0, "R4 general call NACK");
        send_byte(8'h05, ack); send_byte(8'hFF, ack);
        bus_stop();
        chk({7'd0, oe_seen}, 8'd0, "R4 SDA untouched after general call");
        // R11: other pin level address is ignored
        oe_seen = 0;
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack); chk({7'd0, ack}, 8'd0, "R11 R4 wrong pin address NACK");
        send_byte(8'h03, ack); send_byte(8'h77, ack);
        bus_stop();
        chk({7'd0, oe_seen}, 8'd0, "R4 SDA untouched after mismatch");
        watch_oe = 0;
        check_regs("R4 no write after mismatch");
        pin = 0;
        w(4);
        do_write(8'h09, 2);
        check_regs("R11 pin low address");
        do_read(1, 8'h09, 2);
        pin = 1;
        w(4);

        // R9: partial byte ended by STOP
        bus_start();
        send_byte(dev(pin, 1'b0), ack);
        send_byte(8'h05, ack);
        put_bit(1); put_bit(0); put_bit(1);
        bus_stop();
        check_regs("R9 partial byte with STOP");
        // R9: partial byte ended by repeated START, then read at the pointer
        bus_start();
        send_byte(dev(pin, 1'b0), ack);
        send_byte(8'h06, ack);
        mptr = 6;
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_start();
        send_byte(dev(pin, 1'b1), ack); chk({7'd0, ack}, 8'd1, "R3 R9 read after restart");
        begin
            logic [7:0] v;
            recv_byte(1'b0, v);
            chk(v, mreg[6], "R9 R7 pointer kept after partial");
            mptr = wrap(mptr);
        end
        bus_stop();
        check_regs("R9 partial byte with restart");

        // random mix
        for (int t = 0; t < 40; t++) begin
            int kind;
            kind = $urandom_range(0, 2);
            if (kind == 0) begin
                do_write(8'($urandom), $urandom_range(1, 6));
                check_regs("R5 R6 R10 random write");
            end else if (kind == 1) begin
                do_read(1, 8'($urandom), $urandom_range(1, 6));
            end else begin
                do_read(0, 8'h00, $urandom_range(1, 4));
            end
        end
        finish_run();
    end
endmodule